// File: doc/BRIEF.md
# Light-Load Mode Controller

This block chooses the light-load operating modes of a digital power-factor-correction controller. It receives a measured input-power code, with a strobe that marks each fresh measurement, and a one-clock tick at every zero crossing of the AC line. From these it drives three registered selects. The first picks the light-load switching frequency in place of the normal one. The second picks the light-load current-loop filter coefficients in place of the normal ones. The third sheds one PWM phase.

Each decision uses a programmable low-power threshold and a programmable power hysteresis. A feature enters light-load mode when power is strictly below the threshold. It leaves only when power is strictly above threshold plus hysteresis. The filter select is asymmetric. It enters light-load mode only after four full line cycles (eight zero-crossing ticks) with power staying below the threshold. It leaves as soon as a high-power sample arrives.

Each feature has its own enable bit in a shared configuration word. Clearing a feature's bit forces that output back to normal and wipes its state.

Top module: `light_load_ctrl`

## Requirements
- R1: After reset, `freq_light`, `filt_light` and `phase_shed` are all 0 (normal operation). Output encoding is 1 = light-load / phase shed, 0 = normal.
- R2: With `cfg_reg` bit 3 set and `freq_light` at 0, a `sample_valid` strobe with `power_code < pwr_thresh` sets `freq_light` on that clock edge.
- R3: With `freq_light` at 1, the output returns to 0 only on a strobe whose `power_code` exceeds `pwr_thresh + pwr_hyst`. The sum is formed one bit wider, so it never wraps. A sample equal to or below that sum keeps the output at 1.
- R4: `freq_light` and `phase_shed` never change on a clock without a `sample_valid` strobe, unless their enable bit is clear.
- R5: `phase_shed` follows the same threshold and hysteresis rule as R2 and R3. It is gated by `cfg_reg` bit 4.
- R6: With `cfg_reg` bit 5 set, `filt_light` rises on the edge of the eighth `line_tick` (four line cycles of two ticks each). Ticks are counted while the most recent strobed sample was below the threshold.
- R7: A strobed sample at or above `pwr_thresh` before the eighth tick restarts the tick count from zero.
- R8: With `filt_light` at 1, a strobe whose power exceeds `pwr_thresh + pwr_hyst` clears `filt_light` on that same edge.
- R9: Clearing a feature's enable bit forces its output to 0 on the next edge and clears its state, including the tick count and the latched low-power flag. After the bit is set again, the feature starts from normal mode.
- R10: Only bits 3 (frequency), 4 (phase shedding) and 5 (filter) of `cfg_reg` have any effect. All other bits are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sample_valid | input | 1 | One-clock strobe marking a new power measurement |
| power_code | input | PWR_W | Measured input-power code |
| line_tick | input | 1 | One-clock pulse at each AC-line zero crossing |
| cfg_reg | input | 8 | Feature enables: bit 3 frequency, bit 4 phase shed, bit 5 filter |
| pwr_thresh | input | PWR_W | Low-power threshold |
| pwr_hyst | input | PWR_W | Power hysteresis added to the threshold for exit |
| freq_light | output | 1 | 1 = light-load switching frequency selected |
| filt_light | output | 1 | 1 = light-load loop filter selected |
| phase_shed | output | 1 | 1 = one PWM phase disabled |

## Verification
The hardest situation to reach is the filter dwell interrupted at its edges. Cases include a strobe coinciding with a tick, a count restarted one tick short of completion, and an enable dropped in mid-count and later restored. The stimulus reaches these with directed sequences that place strobes and ticks on chosen cycles. A long pseudo-random phase then overlaps strobes and ticks freely, with power codes spread across the band around threshold and threshold plus hysteresis. A behavioural model is compared against every output on every clock.

// File: rtl/light_load_pkg.sv
package light_load_pkg;

  localparam int CFG_W       = 8;
  localparam int FREQ_EN_BIT = 3;
  localparam int SHED_EN_BIT = 4;
  localparam int FILT_EN_BIT = 5;

  typedef enum logic {
    MODE_NORMAL = 1'b0,
    MODE_LIGHT  = 1'b1
  } ll_mode_e;

  typedef struct packed {
    logic filt;
    logic shed;
    logic freq;
  } ll_en_t;

  // Extract the feature enables from the shared configuration word.
  function automatic ll_en_t decode_enables(input logic [CFG_W-1:0] cfg);
    ll_en_t e;
    e.freq = cfg[FREQ_EN_BIT];
    e.shed = cfg[SHED_EN_BIT];
    e.filt = cfg[FILT_EN_BIT];
    return e;
  endfunction

  // Next mode of a threshold/hysteresis latch when a sample is applied.
  function automatic ll_mode_e hyst_step(input ll_mode_e cur, input logic below,
                                         input logic above);
    ll_mode_e nxt;
    nxt = cur;
    if (cur == MODE_NORMAL && below) nxt = MODE_LIGHT;
    else if (cur == MODE_LIGHT && above) nxt = MODE_NORMAL;
    return nxt;
  endfunction

endpackage

// File: rtl/llm_power_cmp.sv
module llm_power_cmp #(
  parameter int PWR_W = 12
) (
  input  logic [PWR_W-1:0] power_code,
  input  logic [PWR_W-1:0] pwr_thresh,
  input  logic [PWR_W-1:0] pwr_hyst,
  output logic             below_o,
  output logic             above_o
);
  localparam int SUM_W = PWR_W + 1;

  logic [SUM_W-1:0] exit_level;

  always_comb begin
    exit_level = {1'b0, pwr_thresh} + {1'b0, pwr_hyst};
    below_o    = (power_code < pwr_thresh);
    above_o    = ({1'b0, power_code} > exit_level);
  end
endmodule

// File: rtl/llm_hyst_mode.sv
module llm_hyst_mode
  import light_load_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic update,
  input  logic below,
  input  logic above,
  output logic mode_o
);
  ll_mode_e mode_q;

  always_ff @(posedge clk) begin
    if (!rst_n)      mode_q <= MODE_NORMAL;
    else if (!enable) mode_q <= MODE_NORMAL;
    else if (update) mode_q <= hyst_step(mode_q, below, above);
  end

  assign mode_o = (mode_q == MODE_LIGHT);
endmodule

// File: rtl/llm_filter_dwell.sv
module llm_filter_dwell
  import light_load_pkg::*;
#(
  parameter int LL_CYCLES       = 4,
  parameter int TICKS_PER_CYCLE = 2,
  localparam int TICK_TGT       = LL_CYCLES * TICKS_PER_CYCLE,
  localparam int CNT_W          = $clog2(TICK_TGT + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             update,
  input  logic             below,
  input  logic             above,
  input  logic             line_tick,
  output logic             mode_o,
  output logic [CNT_W-1:0] dwell_cnt_o,
  output logic             dwell_hit_o
);
  ll_mode_e         mode_q;
  logic [CNT_W-1:0] cnt_q;
  logic             low_q;
  logic             restart;
  logic             count_en;
  logic             exit_now;

  always_comb begin
    restart     = update && !below;
    count_en    = (mode_q == MODE_NORMAL) && !restart && line_tick && low_q;
    dwell_hit_o = count_en && (cnt_q == CNT_W'(TICK_TGT - 1));
    exit_now    = (mode_q == MODE_LIGHT) && update && above;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !enable) begin
      low_q <= 1'b0;
    end else if (update) begin
      low_q <= below;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !enable) begin
      cnt_q <= '0;
    end else if (mode_q == MODE_LIGHT || restart || dwell_hit_o) begin
      cnt_q <= '0;
    end else if (count_en) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !enable) mode_q <= MODE_NORMAL;
    else if (exit_now)     mode_q <= MODE_NORMAL;
    else if (dwell_hit_o)  mode_q <= MODE_LIGHT;
  end

  assign mode_o      = (mode_q == MODE_LIGHT);
  assign dwell_cnt_o = cnt_q;
endmodule

// File: rtl/light_load_ctrl.sv
module light_load_ctrl
  import light_load_pkg::*;
#(
  parameter int PWR_W           = 12,
  parameter int LL_CYCLES       = 4,
  parameter int TICKS_PER_CYCLE = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sample_valid,
  input  logic [PWR_W-1:0] power_code,
  input  logic             line_tick,
  input  logic [CFG_W-1:0] cfg_reg,
  input  logic [PWR_W-1:0] pwr_thresh,
  input  logic [PWR_W-1:0] pwr_hyst,
  output logic             freq_light,
  output logic             filt_light,
  output logic             phase_shed
);
  localparam int TICK_TGT = LL_CYCLES * TICKS_PER_CYCLE;
  localparam int CNT_W    = $clog2(TICK_TGT + 1);
  localparam int N_HYST   = 2;

  ll_en_t           en;
  logic             pwr_below;
  logic             pwr_above;
  logic [N_HYST-1:0] hyst_en;
  logic [N_HYST-1:0] hyst_mode;
  logic [CNT_W-1:0] dwell_cnt;
  logic             dwell_hit;

  assign en = decode_enables(cfg_reg);

  llm_power_cmp #(.PWR_W(PWR_W)) u_cmp (
    .power_code (power_code),
    .pwr_thresh (pwr_thresh),
    .pwr_hyst   (pwr_hyst),
    .below_o    (pwr_below),
    .above_o    (pwr_above)
  );

  assign hyst_en = {en.shed, en.freq};

  for (genvar g = 0; g < N_HYST; g++) begin : g_hyst
    llm_hyst_mode u_mode (
      .clk    (clk),
      .rst_n  (rst_n),
      .enable (hyst_en[g]),
      .update (sample_valid),
      .below  (pwr_below),
      .above  (pwr_above),
      .mode_o (hyst_mode[g])
    );
  end

  llm_filter_dwell #(
    .LL_CYCLES       (LL_CYCLES),
    .TICKS_PER_CYCLE (TICKS_PER_CYCLE)
  ) u_filt (
    .clk         (clk),
    .rst_n       (rst_n),
    .enable      (en.filt),
    .update      (sample_valid),
    .below       (pwr_below),
    .above       (pwr_above),
    .line_tick   (line_tick),
    .mode_o      (filt_light),
    .dwell_cnt_o (dwell_cnt),
    .dwell_hit_o (dwell_hit)
  );

  assign freq_light = hyst_mode[0];
  assign phase_shed = hyst_mode[1];
endmodule

// File: rtl/light_load_chk.sv
module light_load_chk
  import light_load_pkg::*;
#(
  parameter int CNT_W    = 4,
  parameter int TICK_TGT = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sample_valid,
  input logic             line_tick,
  input logic [CFG_W-1:0] cfg_reg,
  input logic             pwr_below,
  input logic             pwr_above,
  input logic [CNT_W-1:0] dwell_cnt,
  input logic             dwell_hit,
  input logic             freq_light,
  input logic             filt_light,
  input logic             phase_shed
);
  // R2
  freq_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_reg[FREQ_EN_BIT] && !freq_light && sample_valid && pwr_below |=> freq_light);

  // R3
  freq_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_reg[FREQ_EN_BIT] && freq_light && !(sample_valid && pwr_above) |=> freq_light);

  // R4
  freq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_valid && cfg_reg[FREQ_EN_BIT] |=> $stable(freq_light));

  // R4
  shed_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_valid && cfg_reg[SHED_EN_BIT] |=> $stable(phase_shed));

  // R5
  shed_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_reg[SHED_EN_BIT] && !phase_shed && sample_valid && pwr_below |=> phase_shed);

  // R6
  filt_rise_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(filt_light) |-> $past(line_tick) && $past(dwell_hit));

  // R6
  dwell_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dwell_cnt < CNT_W'(TICK_TGT));

  // R8
  filt_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_reg[FILT_EN_BIT] && filt_light && sample_valid && pwr_above |=> !filt_light);

  // R9
  disable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_reg[FILT_EN_BIT] |=> !filt_light && (dwell_cnt == '0));

  // R9
  freq_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_reg[FREQ_EN_BIT] |=> !freq_light);
endmodule

bind light_load_ctrl light_load_chk #(
  .CNT_W    (CNT_W),
  .TICK_TGT (TICK_TGT)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .sample_valid (sample_valid),
  .line_tick    (line_tick),
  .cfg_reg      (cfg_reg),
  .pwr_below    (pwr_below),
  .pwr_above    (pwr_above),
  .dwell_cnt    (dwell_cnt),
  .dwell_hit    (dwell_hit),
  .freq_light   (freq_light),
  .filt_light   (filt_light),
  .phase_shed   (phase_shed)
);

// File: tb/light_load_ctrl_tb.sv
module light_load_ctrl_tb;
  localparam int PWR_W = 12;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             sample_valid = 1'b0;
  logic [PWR_W-1:0] power_code = '0;
  logic             line_tick = 1'b0;
  logic [7:0]       cfg_reg = 8'h38;
  logic [PWR_W-1:0] pwr_thresh = 12'd100;
  logic [PWR_W-1:0] pwr_hyst = 12'd20;
  logic             freq_light, filt_light, phase_shed;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;

  // reference model state
  int  m_freq = 0, m_shed = 0, m_filt = 0, m_cnt = 0, m_low = 0;

  always #5 clk = ~clk;

  light_load_ctrl #(.PWR_W(PWR_W)) u_dut (
    .clk (clk), .rst_n (rst_n), .sample_valid (sample_valid),
    .power_code (power_code), .line_tick (line_tick), .cfg_reg (cfg_reg),
    .pwr_thresh (pwr_thresh), .pwr_hyst (pwr_hyst),
    .freq_light (freq_light), .filt_light (filt_light), .phase_shed (phase_shed)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  // Behavioural model: updated at each rising edge from the inputs held since
  // the previous falling edge, then compared one time unit later.
  always @(posedge clk) begin
    int p, th, hy;
    bit lo, hi;
    p  = int'(power_code);
    th = int'(pwr_thresh);
    hy = int'(pwr_hyst);
    lo = (p < th);
    hi = (p > th + hy);
    if (!rst_n) begin
      m_freq = 0; m_shed = 0; m_filt = 0; m_cnt = 0; m_low = 0;
    end else begin
      if (!cfg_reg[3]) m_freq = 0;
      else if (sample_valid) begin
        if (m_freq == 0 && lo) m_freq = 1;
        else if (m_freq == 1 && hi) m_freq = 0;
      end
      if (!cfg_reg[4]) m_shed = 0;
      else if (sample_valid) begin
        if (m_shed == 0 && lo) m_shed = 1;
        else if (m_shed == 1 && hi) m_shed = 0;
      end
      if (!cfg_reg[5]) begin
        m_filt = 0; m_cnt = 0; m_low = 0;
      end else begin
        if (m_filt == 1) begin
          m_cnt = 0;
          if (sample_valid && hi) m_filt = 0;
        end else if (sample_valid && !lo) begin
          m_cnt = 0;
        end else if (line_tick && m_low == 1) begin
          m_cnt++;
          if (m_cnt == 8) begin m_cnt = 0; m_filt = 1; end
        end
        if (sample_valid) m_low = lo ? 1 : 0;
      end
    end
    #1;
    check(int'(freq_light) == m_freq, "R2 R3 R4 model freq_light", int'(freq_light), m_freq);
    check(int'(phase_shed) == m_shed, "R5 model phase_shed", int'(phase_shed), m_shed);
    check(int'(filt_light) == m_filt, "R6 R7 R8 model filt_light", int'(filt_light), m_filt);
  end

  task automatic strobe(input int p);
    @(negedge clk);
    power_code = PWR_W'(p);
    sample_valid = 1'b1;
    @(negedge clk);
    sample_valid = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      line_tick = 1'b1;
      @(negedge clk);
      line_tick = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    idle(3);
    check({freq_light, filt_light, phase_shed} == 3'b000, "R1 reset outputs",
          int'({freq_light, filt_light, phase_shed}), 0);
    rst_n = 1'b1;
    idle(2);

    strobe(150);
    check(freq_light == 1'b0, "R2 high power keeps normal", int'(freq_light), 0);
    strobe(100);
    check(freq_light == 1'b0, "R2 equal to threshold is not below", int'(freq_light), 0);
    strobe(99);
    check(freq_light == 1'b1, "R2 below threshold enters light", int'(freq_light), 1);
    check(phase_shed == 1'b1, "R5 shed follows below threshold", int'(phase_shed), 1);

    strobe(110);
    check(freq_light == 1'b1, "R3 inside band holds", int'(freq_light), 1);
    strobe(120);
    check(freq_light == 1'b1, "R3 at exit level holds", int'(freq_light), 1);
    strobe(121);
    check(freq_light == 1'b0, "R3 above exit level leaves", int'(freq_light), 0);
    check(phase_shed == 1'b0, "R5 shed leaves above exit level", int'(phase_shed), 0);

    power_code = 12'd0;
    idle(5);
    check(freq_light == 1'b0, "R4 no strobe no change", int'(freq_light), 0);

    strobe(50);
    ticks(7);
    check(filt_light == 1'b0, "R6 seven ticks not enough", int'(filt_light), 0);
    @(negedge clk); line_tick = 1'b1;
    @(negedge clk); line_tick = 1'b0;
    check(filt_light == 1'b1, "R6 eighth tick enters light filter", int'(filt_light), 1);

    strobe(130);
    check(filt_light == 1'b0, "R8 immediate exit", int'(filt_light), 0);

    strobe(50);
    ticks(7);
    strobe(100);
    strobe(50);
    ticks(7);
    check(filt_light == 1'b0, "R7 count restarted", int'(filt_light), 0);
    ticks(1);
    check(filt_light == 1'b1, "R7 full count after restart", int'(filt_light), 1);

    cfg_reg = 8'h30;
    @(negedge clk);
    check(freq_light == 1'b0, "R9 freq disabled forces normal", int'(freq_light), 0);
    check(phase_shed == 1'b1, "R10 shed unaffected by bit 3", int'(phase_shed), 1);
    cfg_reg = 8'h38;
    idle(3);
    check(freq_light == 1'b0, "R9 re-enable starts normal", int'(freq_light), 0);
    strobe(40);
    check(freq_light == 1'b1, "R9 re-enabled freq responds", int'(freq_light), 1);

    strobe(200);
    strobe(40);
    ticks(5);
    cfg_reg = 8'h18;
    @(negedge clk);
    cfg_reg = 8'h38;
    strobe(40);
    ticks(7);
    check(filt_light == 1'b0, "R9 count cleared by disable", int'(filt_light), 0);
    ticks(1);
    check(filt_light == 1'b1, "R9 full count after re-enable", int'(filt_light), 1);

    cfg_reg = 8'hFF;
    idle(2);
    cfg_reg = 8'h38 | 8'hC7;
    strobe(200);
    check({freq_light, filt_light, phase_shed} == 3'b000, "R10 other bits ignored",
          int'({freq_light, filt_light, phase_shed}), 0);
    cfg_reg = 8'h38;

    pwr_thresh = 12'd4095;
    pwr_hyst = 12'd4095;
    strobe(10);
    strobe(4095);
    check(freq_light == 1'b1, "R3 wide exit sum does not wrap", int'(freq_light), 1);
    pwr_thresh = 12'd100;
    pwr_hyst = 12'd20;

    begin
      logic [15:0] lf;
      lf = 16'hACE1;
      for (int i = 0; i < 6000; i++) begin
        @(negedge clk);
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
        sample_valid = lf[0] & lf[3];
        line_tick = lf[5] & lf[1];
        power_code = PWR_W'(60 + (lf[15:8] % 90));
        if (lf[11:4] == 8'h3C) cfg_reg = {2'b00, lf[2], lf[9], lf[7], 3'b000};
        if (lf[11:4] == 8'h81) cfg_reg = 8'h38;
      end
      @(negedge clk);
      sample_valid = 1'b0;
      line_tick = 1'b0;
    end

    idle(3);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule